// File: doc/BRIEF.md
# Memory Region Wait-State Generator

This block works out how many extra wait cycles a bus access costs, then holds the requester for that many cycles. The cost depends on the target region (a 4-bit index taken from the upper address bits), the access width (16 or 32 bits) and the access kind. The kind is either a first (non-sequential) access, a sequential access, or a hit in the instruction prefetch path.

Three external memory windows, each mapped at two region indices, and a backup-memory region take their costs from a 16-bit control word that software writes. Fixed costs apply to the external work RAM. Every other region costs nothing. The 32-bit costs are not kept in a table of their own. They are built from the 16-bit pair: two halves plus one turnaround cycle.

For block transfers the block also reports, without a clock delay, the total cost of an N-word burst to the region on its request inputs. The burst uses the 32-bit first and sequential costs.

Top module: `ws_gen`

## Requirements
- R1: After reset, `busy` and `done` are low and the control word reads as 0x0000. At 16 bits the first/sequential costs are: region 2 → 2/2, regions 8–13 → 4/2, 4/2, 4/4, 4/4, 4/8, 4/8, region 14 → 4/4. At 32 bits the first-access costs of regions 8–14 are 7, 7, 9, 9, 13, 13, 9 and region 2 costs 5.
- R2: A 16-bit first access costs 4, 3, 2 or 8 cycles for a 2-bit code of 0, 1, 2 or 3. Window 0 (regions 8 and 9) takes its code from control bits 3:2, window 1 (regions 10 and 11) from bits 6:5, and window 2 (regions 12 and 13) from bits 9:8. Both regions of a window cost the same.
- R3: A 16-bit sequential access costs 1 when the window's sequential bit is set. Window 0 uses bit 4, window 1 bit 7 and window 2 bit 10. When the bit is clear, the cost is 2, 4 or 8 for windows 0, 1 and 2 respectively.
- R4: For any region with a nonzero cost, a 32-bit first access costs the 16-bit first cost + 1 + the 16-bit sequential cost, and a 32-bit sequential access costs twice the 16-bit sequential cost + 1.
- R5: Region 14 takes one cost, selected by control bits 1:0 through the code map of R2, for both first and sequential 16-bit accesses. Its 32-bit cost is twice that value + 1, and its prefetch-hit cost equals its sequential cost.
- R6: When control bit 14 is set, a prefetch hit in regions 8–13 costs 0. When the bit is clear, a prefetch hit costs the same as a sequential access of the same width. In every other region a prefetch hit costs the sequential cost.
- R7: Region 2 always costs 2 (16-bit) or 5 (32-bit) whatever the control word holds. Regions 0, 1, 3–7 and 15 always cost 0.
- R8: A request is accepted in a cycle where `req_valid` is high and `busy` is low. For a cost of W, `done` is high for exactly one cycle, W+1 cycles after the acceptance cycle. `busy` is high from the cycle after acceptance through the `done` cycle.
- R9: A request presented while `busy` is high is ignored: it produces no `done` and does not change the stall in progress.
- R10: A control write takes effect for requests accepted after the write cycle. A request accepted in the same cycle as the write uses the previous control word.
- R11: `burst_cost` equals 1 + the 32-bit first cost + (N−1)·(1 + the 32-bit sequential cost) for the region on `req_region` and N = `req_len`. It is 0 when N is 0.
- R12: A control write during a stall leaves the length of that stall unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word value |
| req_valid | input | 1 | Access request |
| req_region | input | 4 | Target region index |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_seq | input | 1 | Sequential access |
| req_pf | input | 1 | Prefetch hit (takes priority over `req_seq`) |
| req_len | input | LEN_W | Burst length in words for `burst_cost` |
| busy | output | 1 | Stall in progress |
| done | output | 1 | One-cycle pulse ending the stall |
| burst_cost | output | COST_W | Total cycles of a `req_len`-word burst |

## Verification
The assertions assume that reset is held until the first clock edges have passed. They assume that `req_region` and the access flags are stable during the acceptance cycle, since the cost is captured only then. They also assume that `req_valid` carries a known value outside reset. The stimulus changes every input a short delay after the falling clock edge and raises `req_valid` only through tasks that hold it for one clock. A reference model in the bench tracks the acceptance cycle and due cycle of every request and checks `busy`, `done` and `burst_cost` on every cycle. A separate set of tasks measures each stall against costs worked out by hand, including requests that arrive mid-stall and control writes that land in the acceptance cycle or inside a stall.

// File: rtl/ws_pkg.sv
package ws_pkg;

    localparam int REGION_W    = 4;
    localparam int NUM_REGIONS = 1 << REGION_W;
    localparam int CFG_W       = 16;
    localparam int WAIT_W      = 5;
    localparam int WAIT_MAX    = 17;

    // region indices with nonzero cost
    localparam int RG_EXT_RAM = 2;
    localparam int RG_W0_A    = 8;
    localparam int RG_W0_B    = 9;
    localparam int RG_W1_A    = 10;
    localparam int RG_W1_B    = 11;
    localparam int RG_W2_A    = 12;
    localparam int RG_W2_B    = 13;
    localparam int RG_BACKUP  = 14;

    // control word field positions
    localparam int CF_BK_LSB = 0;
    localparam int CF_W0_LSB = 2;
    localparam int CF_W0_SEQ = 4;
    localparam int CF_W1_LSB = 5;
    localparam int CF_W1_SEQ = 7;
    localparam int CF_W2_LSB = 8;
    localparam int CF_W2_SEQ = 10;
    localparam int CF_PF_EN  = 14;

    typedef logic [WAIT_W-1:0] wait_t;

    typedef struct packed {
        wait_t first16;
        wait_t seq16;
        wait_t first32;
        wait_t seq32;
        wait_t pf16;
        wait_t pf32;
    } cost_t;

    typedef enum logic [1:0] {
        AK_FIRST = 2'd0,
        AK_SEQ   = 2'd1,
        AK_PFHIT = 2'd2
    } acc_kind_t;

    function automatic wait_t code_to_wait(input logic [1:0] code);
        case (code)
            2'd0:    return wait_t'(4);
            2'd1:    return wait_t'(3);
            2'd2:    return wait_t'(2);
            default: return wait_t'(8);
        endcase
    endfunction

    function automatic cost_t region_cost(input logic [CFG_W-1:0] cfg, input int idx);
        cost_t c;
        wait_t f;
        wait_t s;
        logic  win;
        logic  live;
        f    = '0;
        s    = '0;
        win  = 1'b0;
        live = 1'b1;
        case (idx)
            RG_EXT_RAM: begin
                f = wait_t'(2);
                s = wait_t'(2);
            end
            RG_W0_A, RG_W0_B: begin
                f   = code_to_wait(cfg[CF_W0_LSB +: 2]);
                s   = cfg[CF_W0_SEQ] ? wait_t'(1) : wait_t'(2);
                win = 1'b1;
            end
            RG_W1_A, RG_W1_B: begin
                f   = code_to_wait(cfg[CF_W1_LSB +: 2]);
                s   = cfg[CF_W1_SEQ] ? wait_t'(1) : wait_t'(4);
                win = 1'b1;
            end
            RG_W2_A, RG_W2_B: begin
                f   = code_to_wait(cfg[CF_W2_LSB +: 2]);
                s   = cfg[CF_W2_SEQ] ? wait_t'(1) : wait_t'(8);
                win = 1'b1;
            end
            RG_BACKUP: begin
                f = code_to_wait(cfg[CF_BK_LSB +: 2]);
                s = f;
            end
            default: live = 1'b0;
        endcase
        c.first16 = f;
        c.seq16   = s;
        c.first32 = live ? wait_t'(f + s + wait_t'(1)) : '0;
        c.seq32   = live ? wait_t'({s, 1'b0} + wait_t'(1)) : '0;
        c.pf16    = (win && cfg[CF_PF_EN]) ? '0 : c.seq16;
        c.pf32    = (win && cfg[CF_PF_EN]) ? '0 : c.seq32;
        return c;
    endfunction

endpackage

// File: rtl/ws_cfg_reg.sv
module ws_cfg_reg
    import ws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= wdata;
        end
    end

endmodule

// File: rtl/ws_cost_table.sv
module ws_cost_table
    import ws_pkg::*;
(
    input  logic [CFG_W-1:0]    cfg,
    input  logic [REGION_W-1:0] region,
    input  logic                wide,
    input  acc_kind_t           kind,
    output cost_t               sel_cost,
    output wait_t               wait_cycles
);

    cost_t tbl [NUM_REGIONS];

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
        assign tbl[g] = region_cost(cfg, g);
    end

    assign sel_cost = tbl[region];

    always_comb begin
        case (kind)
            AK_SEQ:   wait_cycles = wide ? sel_cost.seq32 : sel_cost.seq16;
            AK_PFHIT: wait_cycles = wide ? sel_cost.pf32  : sel_cost.pf16;
            default:  wait_cycles = wide ? sel_cost.first32 : sel_cost.first16;
        endcase
    end

endmodule

// File: rtl/ws_stall_ctr.sv
module ws_stall_ctr
    import ws_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_valid,
    input  wait_t wait_in,
    output logic  busy,
    output logic  done
);

    wait_t remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (req_valid) begin
                busy   <= 1'b1;
                remain <= wait_in;
            end
        end else if (remain == '0) begin
            busy <= 1'b0;
        end else begin
            remain <= remain - wait_t'(1);
        end
    end

    assign done = busy && (remain == '0);

endmodule

// File: rtl/ws_burst_total.sv
module ws_burst_total
    import ws_pkg::*;
#(
    parameter int LEN_W  = 5,
    parameter int COST_W = 10
) (
    input  wait_t             first32,
    input  wait_t             seq32,
    input  logic [LEN_W-1:0]  len,
    output logic [COST_W-1:0] total
);

    logic [COST_W-1:0] head;
    logic [COST_W-1:0] beat;
    logic [COST_W-1:0] rest;

    always_comb begin
        head  = COST_W'(first32) + COST_W'(1);
        beat  = COST_W'(seq32) + COST_W'(1);
        rest  = COST_W'(len) - COST_W'(1);
        total = (len == '0) ? '0 : head + rest * beat;
    end

endmodule

// File: rtl/ws_gen.sv
module ws_gen
    import ws_pkg::*;
#(
    parameter  int LEN_W    = 5,
    localparam int MAX_COST = (1 + WAIT_MAX) * ((1 << LEN_W) - 1),
    localparam int COST_W   = $clog2(MAX_COST + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                req_valid,
    input  logic [REGION_W-1:0] req_region,
    input  logic                req_wide,
    input  logic                req_seq,
    input  logic                req_pf,
    input  logic [LEN_W-1:0]    req_len,
    output logic                busy,
    output logic                done,
    output logic [COST_W-1:0]   burst_cost
);

    logic [CFG_W-1:0] cfg_q;
    acc_kind_t        kind;
    cost_t            rgn_cost;
    wait_t            acc_wait;

    assign kind = req_pf ? AK_PFHIT : (req_seq ? AK_SEQ : AK_FIRST);

    ws_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    ws_cost_table u_tbl (
        .cfg         (cfg_q),
        .region      (req_region),
        .wide        (req_wide),
        .kind        (kind),
        .sel_cost    (rgn_cost),
        .wait_cycles (acc_wait)
    );

    ws_stall_ctr u_stall (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .wait_in   (acc_wait),
        .busy      (busy),
        .done      (done)
    );

    ws_burst_total #(.LEN_W(LEN_W), .COST_W(COST_W)) u_burst (
        .first32 (rgn_cost.first32),
        .seq32   (rgn_cost.seq32),
        .len     (req_len),
        .total   (burst_cost)
    );

endmodule

// File: rtl/ws_gen_chk.sv
module ws_gen_chk
    import ws_pkg::*;
#(
    parameter int LEN_W  = 5,
    parameter int COST_W = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [REGION_W-1:0] req_region,
    input logic [LEN_W-1:0]    req_len,
    input logic                busy,
    input logic                done,
    input logic [COST_W-1:0]   burst_cost,
    input wait_t               acc_wait
);

    logic              t_act;
    logic [WAIT_W:0]   t_el;
    logic [WAIT_W:0]   t_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_act <= 1'b0;
            t_el  <= '0;
            t_w   <= '0;
        end else if (req_valid && !busy) begin
            t_act <= 1'b1;
            t_el  <= '0;
            t_w   <= {1'b0, acc_wait};
        end else if (t_act) begin
            if (done) t_act <= 1'b0;
            t_el <= t_el + 1'b1;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));

    a_r8_done_on_time: assert property (@(posedge clk) disable iff (rst)
        t_act |-> (done == (t_el == t_w)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_busy_held: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    a_r9_start_needs_request: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    a_r7_free_region: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_region inside {4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd15}))
        |=> done);

    a_r11_empty_burst: assert property (@(posedge clk) disable iff (rst)
        (req_len == '0) |-> (burst_cost == '0));

endmodule

bind ws_gen ws_gen_chk #(.LEN_W(LEN_W), .COST_W(COST_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_region (req_region),
    .req_len    (req_len),
    .busy       (busy),
    .done       (done),
    .burst_cost (burst_cost),
    .acc_wait   (acc_wait)
);

// File: tb/ws_gen_test.sv
module ws_gen_test;

    localparam int LEN_W  = 5;
    localparam int COST_W = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [15:0]       cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic [3:0]        req_region = '0;
    logic              req_wide = 1'b0;
    logic              req_seq = 1'b0;
    logic              req_pf = 1'b0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              busy;
    logic              done;
    logic [COST_W-1:0] burst_cost;

    always #10 clk = ~clk;

    ws_gen #(.LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_region(req_region), .req_wide(req_wide),
        .req_seq(req_seq), .req_pf(req_pf), .req_len(req_len),
        .busy(busy), .done(done), .burst_cost(burst_cost)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int m_acc = -1;
    int m_due = -1;
    logic [15:0] m_cfg = '0;
    bit mon_en = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural cost reference from the requirement text
    function automatic void ref_base(input logic [15:0] c, input int r,
                                     output int f, output int s, output bit win, output bit live);
        int cm[4] = '{4, 3, 2, 8};
        f = 0; s = 0; win = 0; live = 1;
        if (r == 2) begin f = 2; s = 2; end
        else if (r == 8 || r == 9)   begin f = cm[c[3:2]]; s = c[4]  ? 1 : 2; win = 1; end
        else if (r == 10 || r == 11) begin f = cm[c[6:5]]; s = c[7]  ? 1 : 4; win = 1; end
        else if (r == 12 || r == 13) begin f = cm[c[9:8]]; s = c[10] ? 1 : 8; win = 1; end
        else if (r == 14) begin f = cm[c[1:0]]; s = f; end
        else live = 0;
    endfunction

    function automatic int ref_wait(input logic [15:0] c, input int r,
                                    input bit w, input bit sq, input bit pf);
        int f, s; bit win, live;
        int f32, s32;
        ref_base(c, r, f, s, win, live);
        if (!live) return 0;
        f32 = f + 1 + s;
        s32 = 2 * s + 1;
        if (pf) return (win && c[14]) ? 0 : (w ? s32 : s);
        if (sq) return w ? s32 : s;
        return w ? f32 : f;
    endfunction

    function automatic int ref_burst(input logic [15:0] c, input int r, input int n);
        if (n == 0) return 0;
        return 1 + ref_wait(c, r, 1, 0, 0) + (n - 1) * (1 + ref_wait(c, r, 1, 1, 0));
    endfunction

    // cycle model: acceptance cycle and due cycle
    always @(posedge clk) begin
        bit mb;
        if (rst) begin
            m_acc = -1; m_due = -1; m_cfg = '0; cyc = 0;
        end else begin
            mb = (cyc > m_acc) && (cyc <= m_due);
            if (req_valid && !mb) begin
                m_acc = cyc;
                m_due = cyc + ref_wait(m_cfg, int'(req_region), req_wide, req_seq, req_pf) + 1;
            end
            if (cfg_we) m_cfg = cfg_wdata;
            cyc++;
        end
    end

    always @(negedge clk) begin
        int eb;
        if (mon_en) begin
            eb = ((cyc > m_acc) && (cyc <= m_due)) ? 1 : 0;
            chk(busy === eb[0], "R8 busy model", int'(busy), eb);
            chk(done === (cyc == m_due), "R8/R9 done model", int'(done), int'(cyc == m_due));
            eb = ref_burst(m_cfg, int'(req_region), int'(req_len));
            chk(int'(burst_cost) == eb, "R11 burst model", int'(burst_cost), eb);
        end
    end

    task automatic issue(input int r, input bit w, input bit sq, input bit pf, input int exp,
                         input string tag, input int cfg_when = -1, input logic [15:0] cfg_val = '0);
        int n = 0;
        bit got = 0;
        @(negedge clk);
        #2;
        req_region = 4'(r); req_wide = w; req_seq = sq; req_pf = pf; req_len = 1;
        req_valid = 1'b1;
        cfg_we = (cfg_when == 0); cfg_wdata = cfg_val;
        while (!got && n < 40) begin
            @(negedge clk);
            n++;
            if (done) got = 1;
            #2;
            if (n == 1) req_valid = 1'b0;
            cfg_we = (n == cfg_when);
        end
        cfg_we = 1'b0;
        chk(got && (n == exp + 1), tag, n - 1, exp);
    endtask

    task automatic wcfg(input logic [15:0] v);
        @(negedge clk); #2;
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic bcheck(input int r, input int n, input int exp, input string tag);
        @(negedge clk); #2;
        req_valid = 1'b0; req_region = 4'(r); req_len = LEN_W'(n);
        @(negedge clk);
        chk(int'(burst_cost) == exp, tag, int'(burst_cost), exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int dcount;
        int dfirst;
        repeat (3) @(negedge clk);
        #2 rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", int'(busy) + int'(done), 0);

        // reset cost tables (control word 0)
        issue(8, 0, 0, 0, 4, "R1 region8 first16");
        issue(8, 1, 0, 0, 7, "R1 region8 first32");
        issue(10, 1, 0, 0, 9, "R1 region10 first32");
        issue(12, 1, 0, 0, 13, "R1 region12 first32");
        issue(12, 1, 1, 0, 17, "R1 R4 region12 seq32");
        issue(14, 1, 0, 0, 9, "R1 region14 first32");
        issue(2, 0, 0, 0, 2, "R7 region2 first16");
        issue(0, 1, 0, 0, 0, "R7 region0 zero");
        issue(15, 0, 0, 0, 0, "R7 region15 zero");
        issue(8, 0, 0, 1, 2, "R6 prefetch off region8");
        bcheck(12, 16, 284, "R11 region12 len16");
        bcheck(0, 3, 3, "R11 region0 len3");

        // control word 0x0757
        wcfg(16'h0757);
        issue(9, 0, 0, 0, 3, "R2 region9 code1");
        issue(8, 0, 0, 0, 3, "R2 region8 mirror");
        issue(9, 0, 1, 0, 1, "R3 region9 seqbit");
        issue(9, 1, 0, 0, 5, "R4 region9 first32");
        issue(9, 1, 1, 0, 3, "R4 region9 seq32");
        issue(11, 0, 0, 0, 2, "R2 region11 code2");
        issue(10, 0, 1, 0, 4, "R3 region10 seq clear");
        issue(11, 1, 0, 0, 7, "R4 region11 first32");
        issue(13, 0, 0, 0, 8, "R2 region13 code3");
        issue(12, 1, 0, 0, 10, "R4 region12 first32");
        issue(14, 0, 0, 0, 8, "R5 region14 first16");
        issue(14, 1, 1, 0, 17, "R5 region14 seq32");
        issue(14, 0, 0, 1, 8, "R5 region14 prefetch");
        issue(2, 1, 0, 0, 5, "R7 region2 first32");
        issue(9, 0, 0, 1, 1, "R6 prefetch off region9");
        bcheck(9, 4, 18, "R11 region9 len4");
        bcheck(13, 1, 11, "R11 region13 len1");
        bcheck(13, 0, 0, "R11 len0");

        // request arriving during a stall is dropped
        dcount = 0; dfirst = -1;
        @(negedge clk); #2;
        req_region = 4'd13; req_wide = 0; req_seq = 0; req_pf = 0; req_valid = 1'b1;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            if (done) begin dcount++; if (dfirst < 0) dfirst = k; end
            #2;
            req_valid = (k == 3);
            if (k == 3) req_region = 4'd0;
        end
        req_valid = 1'b0;
        chk(dcount == 1, "R9 one done only", dcount, 1);
        chk(dfirst == 9, "R9 stall unchanged", dfirst, 9);
        chk(!busy, "R9 idle afterwards", int'(busy), 0);

        // control write inside a stall, new word 0x4008
        issue(12, 1, 0, 0, 10, "R12 write mid-stall", 2, 16'h4008);
        issue(8, 0, 0, 0, 2, "R2 region8 code2");
        issue(8, 0, 0, 1, 0, "R6 prefetch on region8");
        issue(10, 1, 0, 1, 0, "R6 prefetch on region10 wide");
        issue(14, 0, 0, 1, 4, "R6 region14 prefetch unaffected");
        issue(2, 0, 0, 1, 2, "R6 R7 region2 prefetch");

        // write in the acceptance cycle
        issue(8, 0, 0, 0, 2, "R10 same-cycle old word", 0, 16'h0757);
        issue(8, 0, 0, 0, 3, "R10 next request new word");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule